// File: doc/BRIEF.md
# Three-Phase Waveform Sample Fetcher

This block turns a speed word into three signed, amplitude-scaled waveform samples, one per output phase, for a downstream carrier comparator. It keeps a fixed-point angle counter that covers one electrical revolution in 1536 integer steps. It derives a second angle 512 steps behind the first and a third 1024 steps behind. For each of the three angles it fetches one 8-bit magnitude sample from a narrow external ROM that stores half a cycle. It restores the sign for the second half of the cycle and scales the result by an amplitude gain.

The ROM is 4 bits wide. Each sample is therefore split across two banks, and the top address bit picks the bank. Every fetch frame makes six ROM reads: low and high nibble for red, then yellow, then blue. Each read holds its address for a programmable number of clock cycles plus one. After the sixth read one update cycle follows. In that cycle the three scaled results are loaded, a one-cycle strobe is raised and the angle counter steps forward or back by the speed word. A hold input parks the angle at zero. A zero-phase marker is high during the last third of the red revolution.

Top module: `wave_fetch_top`

## Requirements
- R1: While rst_n is low, amp_red, amp_yel, amp_blu, amp_new and zpp are 0, and rom_addr is 0.
- R2: For an angle a (0..1535), the half index is i = a mod 768. The low nibble is read at address i and the high nibble at address 1024 + i. The six reads go red-low, red-high, yellow-low, yellow-high, blue-low, blue-high. Each read holds its address for rom_wait + 1 cycles.
- R3: The 8-bit sample is the high-bank nibble in bits 7:4, joined with the low-bank nibble in bits 3:0.
- R4: When a phase angle is 768 or more, the output of that phase is the negated scaled magnitude. Otherwise it is the positive value.
- R5: The scaled magnitude is floor(sample × G / 255), where G = {overmod, amp_word} is a 9-bit gain. This gives 0..200 % of the stored shape.
- R6: The red angle is the accumulator integer part. The yellow angle is (red − 512) mod 1536 and the blue angle is (red − 1024) mod 1536.
- R7: The accumulator is 15 bits wide. The angle is its value shifted right by 4. With dir_rev = 0, each update slot adds phase_inc modulo 24576.
- R8: With dir_rev = 1, each update slot subtracts phase_inc modulo 24576. The angle continues from its current value with no jump.
- R9: When cnt_hold_n is low at an update slot, the accumulator becomes 0, so the next frame fetches red at 0°.
- R10: A frame lasts 6 × (rom_wait + 1) + 1 cycles. amp_new is a one-cycle pulse in the first cycle of every frame after the first, and the amplitude outputs change only with it.
- R11: zpp is high exactly when the red angle is 1024 or more. In forward running it falls when red passes 0°; in reverse running it rises there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| phase_inc | input | 12 | Speed word added to or subtracted from the accumulator each frame |
| dir_rev | input | 1 | 0 = forward (count up), 1 = reverse (count down) |
| cnt_hold_n | input | 1 | Active low; parks the angle at 0 at the next update slot |
| amp_word | input | 8 | Amplitude gain, low 8 bits |
| overmod | input | 1 | Amplitude gain ninth bit (doubling range) |
| rom_wait | input | 4 | Extra wait cycles per ROM read |
| rom_data | input | 4 | ROM data nibble |
| rom_addr | output | 11 | ROM address; bit 10 selects the high-nibble bank |
| amp_red | output | 11 | Signed scaled sample, red phase |
| amp_yel | output | 11 | Signed scaled sample, yellow phase |
| amp_blu | output | 11 | Signed scaled sample, blue phase |
| amp_new | output | 1 | One-cycle strobe marking a fresh set of samples |
| zpp | output | 1 | Zero-phase marker, high in the last third of the red revolution |

## Verification
Counted from reset release, the address for read r of a frame is valid in cycles r(W+1) through r(W+1)+W of that frame, where W is rom_wait. The update slot is cycle 6(W+1), and the new amplitudes and amp_new appear one cycle after that slot. The bench tracks the frame position by counting rising edges since release and samples on falling edges. At each update slot it predicts the three results from its own angle model and the control inputs then present, and queues them. A monitor compares the queued values when the strobe is due. The controls change only just after a strobe, so each change takes effect in a predictable frame.

// File: rtl/wf_pkg.sv
package wf_pkg;

  localparam int unsigned ANG_W     = 11;
  localparam int unsigned IDX_W     = 10;
  localparam int unsigned NIB_W     = 4;
  localparam int unsigned SAMP_W    = 2 * NIB_W;
  localparam int unsigned GAIN_W    = SAMP_W + 1;
  localparam int unsigned MAG_W     = SAMP_W + 2;
  localparam int unsigned AMP_OUT_W = MAG_W + 1;
  localparam int unsigned N_PHASE   = 3;
  localparam int unsigned N_READS   = 2 * N_PHASE;
  localparam int unsigned PROD_W    = SAMP_W + GAIN_W;

  localparam logic [ANG_W-1:0] HALF_STEPS = 11'd768;
  localparam logic [ANG_W:0]   FULL_STEPS = 12'd1536;
  localparam logic [ANG_W-1:0] PHASE_GAP  = 11'd512;
  localparam logic [ANG_W-1:0] ZPP_START  = 11'd1024;

  typedef struct packed {
    logic             neg;
    logic [IDX_W-1:0] idx;
  } half_t;

  // angle that trails ang by lag steps, modulo one revolution
  function automatic logic [ANG_W-1:0] lag_angle(input logic [ANG_W-1:0] ang,
                                                 input logic [ANG_W-1:0] lag);
    logic [ANG_W:0] r;
    if (ang >= lag) r = {1'b0, ang} - {1'b0, lag};
    else            r = {1'b0, ang} + FULL_STEPS - {1'b0, lag};
    return r[ANG_W-1:0];
  endfunction

  // fold a full-cycle angle into a half-cycle index plus sign
  function automatic half_t split_half(input logic [ANG_W-1:0] ang);
    half_t            h;
    logic [ANG_W-1:0] t;
    if (ang >= HALF_STEPS) begin
      t     = ang - HALF_STEPS;
      h.neg = 1'b1;
    end else begin
      t     = ang;
      h.neg = 1'b0;
    end
    h.idx = t[IDX_W-1:0];
    return h;
  endfunction

  // floor(sample * gain / 255)
  function automatic logic [MAG_W-1:0] scale_mag(input logic [SAMP_W-1:0] s,
                                                 input logic [GAIN_W-1:0] g);
    logic [PROD_W-1:0] p;
    logic [PROD_W-1:0] q;
    p = PROD_W'(s) * PROD_W'(g);
    q = p / PROD_W'(255);
    return q[MAG_W-1:0];
  endfunction

  function automatic logic signed [AMP_OUT_W-1:0] apply_sign(input logic [MAG_W-1:0] m,
                                                             input logic neg);
    logic signed [AMP_OUT_W-1:0] v;
    v = $signed({1'b0, m});
    return neg ? -v : v;
  endfunction

endpackage

// File: rtl/wf_phase_acc.sv
module wf_phase_acc
  import wf_pkg::*;
#(
  parameter int unsigned FRAC_W = 4,
  parameter int unsigned INC_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              hold_n,
  input  logic              dir_rev,
  input  logic [INC_W-1:0]  phase_inc,
  output logic [ANG_W-1:0]  red_angle,
  output logic              zpp
);

  localparam int unsigned ACC_W = ANG_W + FRAC_W;
  localparam logic [ACC_W:0] MODULUS = (ACC_W+1)'(FULL_STEPS) << FRAC_W;

  logic [ACC_W-1:0] acc_q;

  function automatic logic [ACC_W-1:0] advance(input logic [ACC_W-1:0] cur,
                                               input logic [INC_W-1:0] inc,
                                               input logic rev);
    logic [ACC_W:0] c;
    logic [ACC_W:0] d;
    logic [ACC_W:0] r;
    c = {1'b0, cur};
    d = (ACC_W+1)'(inc);
    if (!rev) begin
      r = c + d;
      if (r >= MODULUS) r = r - MODULUS;
    end else begin
      if (c >= d) r = c - d;
      else        r = c + MODULUS - d;
    end
    return r[ACC_W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc_q <= '0;
    else if (step_en) acc_q <= hold_n ? advance(acc_q, phase_inc, dir_rev) : '0;
  end

  assign red_angle = acc_q[ACC_W-1:FRAC_W];
  assign zpp       = (red_angle >= ZPP_START);

  AST_ACC_RANGE: assert property (@(posedge clk) disable iff (!rst_n) {1'b0, acc_q} < MODULUS); // R7
  AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (step_en && !hold_n) |=> (red_angle == '0)); // R9
  AST_MID_FRAME: assert property (@(posedge clk) disable iff (!rst_n) !step_en |=> $stable(red_angle)); // R10

endmodule

// File: rtl/wf_fetch_seq.sv
module wf_fetch_seq
  import wf_pkg::*;
#(
  parameter int unsigned WAIT_W = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [WAIT_W-1:0]               rom_wait,
  input  logic [ANG_W-1:0]                red_angle,
  input  logic [NIB_W-1:0]                rom_data,
  output logic [ANG_W-1:0]                rom_addr,
  output logic [N_PHASE-1:0][SAMP_W-1:0]  samp_o,
  output logic [N_PHASE-1:0]              neg_o,
  output logic                            frame_end
);

  localparam logic [2:0] UPD_SLOT = 3'(N_READS);

  logic [2:0]        rd_idx;
  logic [WAIT_W-1:0] wait_cnt;
  logic [1:0]        cur_ph;
  logic              cur_nib;
  logic              capture_now;
  logic [IDX_W-1:0]  sel_idx;
  half_t             ph_half [N_PHASE];

  assign cur_ph      = rd_idx[2:1];
  assign cur_nib     = rd_idx[0];
  assign frame_end   = (rd_idx == UPD_SLOT);
  assign capture_now = !frame_end && (wait_cnt == rom_wait);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_idx   <= '0;
      wait_cnt <= '0;
    end else if (frame_end) begin
      rd_idx   <= '0;
      wait_cnt <= '0;
    end else if (capture_now) begin
      rd_idx   <= rd_idx + 3'd1;
      wait_cnt <= '0;
    end else begin
      wait_cnt <= wait_cnt + 1'b1;
    end
  end

  for (genvar p = 0; p < N_PHASE; p++) begin : g_phase
    logic [ANG_W-1:0]  ang;
    logic [SAMP_W-1:0] samp_r;

    assign ang        = lag_angle(red_angle, ANG_W'(p) * PHASE_GAP);
    assign ph_half[p] = split_half(ang);
    assign samp_o[p]  = samp_r;
    assign neg_o[p]   = ph_half[p].neg;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        samp_r <= '0;
      end else if (capture_now && (int'(cur_ph) == p)) begin
        if (cur_nib) samp_r[SAMP_W-1:NIB_W] <= rom_data;
        else         samp_r[NIB_W-1:0]      <= rom_data;
      end
    end
  end

  always_comb begin
    sel_idx = ph_half[0].idx;
    for (int p = 0; p < N_PHASE; p++) begin
      if (!frame_end && (int'(cur_ph) == p)) sel_idx = ph_half[p].idx;
    end
  end

  assign rom_addr = {cur_nib & !frame_end, sel_idx};

  AST_ADDR_HALF: assert property (@(posedge clk) disable iff (!rst_n) ({1'b0, rom_addr[IDX_W-1:0]} < HALF_STEPS)); // R2
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!frame_end && !capture_now) |=> $stable(rom_addr)); // R2
  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) rd_idx <= UPD_SLOT); // R10
  AST_END_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) frame_end |=> !frame_end); // R10

endmodule

// File: rtl/wf_scaler.sv
module wf_scaler
  import wf_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load,
  input  logic [SAMP_W-1:0]            samp_i,
  input  logic                         neg_i,
  input  logic [GAIN_W-1:0]            gain_i,
  output logic signed [AMP_OUT_W-1:0]  amp_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    amp_o <= '0;
    else if (load) amp_o <= apply_sign(scale_mag(samp_i, gain_i), neg_i);
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !load |=> $stable(amp_o)); // R10
  AST_NEG_SIDE: assert property (@(posedge clk) disable iff (!rst_n) (load && neg_i) |=> (amp_o <= 0)); // R4
  AST_POS_SIDE: assert property (@(posedge clk) disable iff (!rst_n) (load && !neg_i) |=> (amp_o >= 0)); // R4

endmodule

// File: rtl/wave_fetch_top.sv
module wave_fetch_top
  import wf_pkg::*;
#(
  parameter int unsigned FRAC_W = 4,
  parameter int unsigned WAIT_W = 4,
  parameter int unsigned INC_W  = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [INC_W-1:0]             phase_inc,
  input  logic                         dir_rev,
  input  logic                         cnt_hold_n,
  input  logic [SAMP_W-1:0]            amp_word,
  input  logic                         overmod,
  input  logic [WAIT_W-1:0]            rom_wait,
  input  logic [NIB_W-1:0]             rom_data,
  output logic [ANG_W-1:0]             rom_addr,
  output logic signed [AMP_OUT_W-1:0]  amp_red,
  output logic signed [AMP_OUT_W-1:0]  amp_yel,
  output logic signed [AMP_OUT_W-1:0]  amp_blu,
  output logic                         amp_new,
  output logic                         zpp
);

  logic [ANG_W-1:0]               red_angle;
  logic                           frame_end;
  logic [N_PHASE-1:0][SAMP_W-1:0] samp;
  logic [N_PHASE-1:0]             neg;
  logic [GAIN_W-1:0]              gain;
  logic signed [AMP_OUT_W-1:0]    amp_arr [N_PHASE];

  assign gain = {overmod, amp_word};

  wf_phase_acc #(.FRAC_W(FRAC_W), .INC_W(INC_W)) i_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en   (frame_end),
    .hold_n    (cnt_hold_n),
    .dir_rev   (dir_rev),
    .phase_inc (phase_inc),
    .red_angle (red_angle),
    .zpp       (zpp)
  );

  wf_fetch_seq #(.WAIT_W(WAIT_W)) i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .rom_wait  (rom_wait),
    .red_angle (red_angle),
    .rom_data  (rom_data),
    .rom_addr  (rom_addr),
    .samp_o    (samp),
    .neg_o     (neg),
    .frame_end (frame_end)
  );

  for (genvar p = 0; p < N_PHASE; p++) begin : g_scale
    wf_scaler i_scl (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (frame_end),
      .samp_i (samp[p]),
      .neg_i  (neg[p]),
      .gain_i (gain),
      .amp_o  (amp_arr[p])
    );
  end

  assign amp_red = amp_arr[0];
  assign amp_yel = amp_arr[1];
  assign amp_blu = amp_arr[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) amp_new <= 1'b0;
    else        amp_new <= frame_end;
  end

  AST_NEW_PULSE: assert property (@(posedge clk) disable iff (!rst_n) amp_new |=> !amp_new); // R10
  AST_ZERO_GAIN: assert property (@(posedge clk) disable iff (!rst_n) (frame_end && gain == '0) |=> (amp_red == 0 && amp_yel == 0 && amp_blu == 0)); // R5

endmodule

// File: tb/test_wave_fetch_top.sv
module test_wave_fetch_top;

  localparam int MODV = 1536 * 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic [11:0] phase_inc = 12'd16;
  logic        dir_rev = 1'b0;
  logic        cnt_hold_n = 1'b1;
  logic [7:0]  amp_word = 8'd255;
  logic        overmod = 1'b0;
  logic [3:0]  rom_wait = 4'd0;
  logic [3:0]  rom_data;
  logic [10:0] rom_addr;
  logic signed [10:0] amp_red, amp_yel, amp_blu;
  logic        amp_new, zpp;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int sb_q[$];
  int m_acc = 0;
  int k = 0;
  bit rst_checked = 1'b0;

  always #2 clk = ~clk;

  wave_fetch_top i_wave_fetch_top (
    .clk(clk), .rst_n(rst_n), .phase_inc(phase_inc), .dir_rev(dir_rev),
    .cnt_hold_n(cnt_hold_n), .amp_word(amp_word), .overmod(overmod),
    .rom_wait(rom_wait), .rom_data(rom_data), .rom_addr(rom_addr),
    .amp_red(amp_red), .amp_yel(amp_yel), .amp_blu(amp_blu),
    .amp_new(amp_new), .zpp(zpp)
  );

  function automatic int sample_at(input int i);
    return ((i * 37) + (i >> 4) + 11) & 255;
  endfunction

  // ROM model: split across two nibble banks
  always_comb begin
    int s;
    s = sample_at(int'(rom_addr[9:0]));
    rom_data = rom_addr[10] ? 4'((s >> 4) & 15) : 4'(s & 15);
  end

  function automatic int phase_angle(input int acc, input int p);
    return ((acc >> 4) - 512 * p + 1536) % 1536;
  endfunction

  task automatic check_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // driver side of the scoreboard: predict one frame's results
  task automatic predict_frame();
    int gain;
    gain = (int'(overmod) << 8) | int'(amp_word);
    for (int p = 0; p < 3; p++) begin
      int ang, mag;
      ang = phase_angle(m_acc, p);
      mag = (sample_at(ang % 768) * gain) / 255;
      sb_q.push_back(ang >= 768 ? -mag : mag);
    end
    if (!cnt_hold_n)   m_acc = 0;
    else if (!dir_rev) m_acc = (m_acc + int'(phase_inc)) % MODV;
    else               m_acc = (m_acc - int'(phase_inc) + MODV) % MODV;
  endtask

  // monitor
  always @(negedge clk) begin
    int w, len;
    w   = int'(rom_wait);
    len = 6 * (w + 1) + 1;
    if (!rst_n) begin
      k = 0;
      m_acc = 0;
      sb_q.delete();
      if (!rst_checked) begin
        rst_checked = 1'b1;
        check_eq("R1 amp_red", int'(amp_red), 0);
        check_eq("R1 amp_yel", int'(amp_yel), 0);
        check_eq("R1 amp_blu", int'(amp_blu), 0);
        check_eq("R1 amp_new", int'(amp_new), 0);
        check_eq("R1 zpp", int'(zpp), 0);
        check_eq("R1 rom_addr", int'(rom_addr), 0);
      end
    end else begin
      rst_checked = 1'b0;
      k = (k + 1 == len) ? 0 : k + 1;
      check_eq("R10 amp_new strobe", int'(amp_new), (k == 0) ? 1 : 0);
      if (k == 0) begin
        if (sb_q.size() < 3) begin
          checks++; errors++;
          $display("FAIL R10: actual strobe with %0d queued expected 3", sb_q.size());
        end else begin
          check_eq("R3 R4 R5 R6 red",    int'(amp_red), sb_q.pop_front());
          check_eq("R3 R4 R5 R6 yellow", int'(amp_yel), sb_q.pop_front());
          check_eq("R3 R4 R5 R6 blue",   int'(amp_blu), sb_q.pop_front());
        end
      end
      if (k < len - 1) begin
        int r, ang;
        r   = k / (w + 1);
        ang = phase_angle(m_acc, r / 2);
        check_eq("R2 R7 R8 R9 rom_addr", int'(rom_addr), (r % 2) * 1024 + ang % 768);
      end
      check_eq("R11 zpp", int'(zpp), ((m_acc >> 4) >= 1024) ? 1 : 0);
      if (k == len - 1) predict_frame();
    end
  end

  task automatic frames(input int n);
    repeat (n) @(posedge amp_new);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1 rst_n = 1'b0;
    repeat (4) @(negedge clk);
    #1 rst_n = 1'b1;
    frames(12);                                   // R7 single-step forward
    phase_inc = 12'd3000; amp_word = 8'd204;
    frames(20);                                   // R4 R11 wrap through both halves
    overmod = 1'b1; amp_word = 8'd255;
    frames(10);                                   // R5 doubled range
    dir_rev = 1'b1; phase_inc = 12'd2500; overmod = 1'b0; amp_word = 8'd150;
    frames(20);                                   // R8 reverse
    cnt_hold_n = 1'b0;
    frames(3);                                    // R9 parked at zero
    cnt_hold_n = 1'b1; phase_inc = 12'd5;
    frames(6);                                    // R8 reverse out of zero
    amp_word = 8'd0;
    frames(4);                                    // R5 zero gain
    @(negedge clk); #1 rst_n = 1'b0;
    rom_wait = 4'd2; dir_rev = 1'b0; phase_inc = 12'd1234; amp_word = 8'd100;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    frames(15);                                   // R2 R10 longer reads
    repeat (3) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

endmodule